// File: doc/BRIEF.md
# DMA Physical Address Generator

This block builds the physical memory address presented on each DMA transfer cycle for one channel. It holds a 16-bit current address, an 8-bit page register and an 8-bit upper-page register, and maps them onto a 32-bit physical address. The mapping depends on whether the channel moves bytes or 16-bit words. A word channel shifts the current address up by one bit and ignores the least significant page bit, so each page covers a 128 KB region.

Software first loads the current address and writes the page register. Writing the upper-page register is the last step of setup. That write arms extended mode. On every step strobe the current address advances by one. Without extended mode the 16-bit address wraps inside its page, so a transfer stays within its 64 KB (byte) or 128 KB (word) window. With extended mode armed, a rollover from 0xFFFF carries into the combined upper-page/page value, so the transfer moves on into the next window.

Top module: `dma_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, the current address, page, upper page and extended-mode flag are all zero, so `phys_addr` reads 0x00000000.
- R2: When `word_chan` is 0 (byte channel), `phys_addr` = {upper page[7:0], page[7:0], current address[15:0]}.
- R3: When `word_chan` is 1 (word channel), `phys_addr` = {upper page[7:0], page[7:1], current address[15:0], 1'b0}. Page bit 0 has no effect on the output.
- R4: A cycle with `addr_ld` high sets the current address to `addr_ld_data`, visible on `phys_addr` one clock later. When `addr_ld` and `step` are both high, the load wins and no step or carry happens.
- R5: A cycle with `step` high and `addr_ld` low increments the current address by one, modulo 2^16, visible one clock later.
- R6: With extended mode disarmed, a step from current address 0xFFFF wraps it to 0x0000 and leaves the page and upper page unchanged.
- R7: A write to the upper page arms extended mode. On a byte channel with extended mode armed, a step from 0xFFFF adds one to the 16-bit value {upper page, page}.
- R8: On a word channel with extended mode armed, a step from 0xFFFF adds two to {upper page, page}, so the carry enters at page bit 1.
- R9: A write to the page register alone disarms extended mode. If both page writes happen in the same cycle, extended mode ends up armed.
- R10: In a cycle with no step, no load, no page write and no change of `word_chan`, `phys_addr` holds its value across the next clock.
- R11: Any page or upper-page write in the same cycle as a rollover step takes priority, and the carry is dropped. Written registers take the written data; an unwritten one keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_chan | input | 1 | Channel type: 0 byte, 1 word |
| page_we | input | 1 | Write strobe for the page register (disarms extended mode) |
| page_wdata | input | 8 | Page register write data |
| upage_we | input | 1 | Write strobe for the upper-page register (arms extended mode) |
| upage_wdata | input | 8 | Upper-page register write data |
| addr_ld | input | 1 | Load strobe for the 16-bit current address |
| addr_ld_data | input | 16 | Current address load value |
| step | input | 1 | Transfer strobe: advance the current address |
| phys_addr | output | 32 | Physical address of the current transfer |

## Verification
Every register update (load, step, page writes, carry and the extended-mode flag) shows on `phys_addr` exactly one clock after the edge that captures the strobe. `word_chan` acts on the output with no delay, because the mapping is combinational. The bench applies stimulus on the falling edge and samples one time unit after the next rising edge. Each sample is compared with an arithmetic model that the bench advances under the same rule. Sweeps cover both channel types, both extended-mode states, page values with bit 0 set and clear, and a page of 0xFF so that the carry ripples into the upper page.

// File: rtl/dma_addr_pkg.sv
// Package: shared types and helpers for the DMA address generator.
// Assumes: one page byte and one upper-page byte per channel.
package dma_addr_pkg;

    // Transfer width of the channel being served.
    typedef enum logic {
        XFER_BYTE = 1'b0,
        XFER_WORD = 1'b1
    } xfer_kind_e;

    // Amount added to the combined page on an extended rollover.
    function automatic int unsigned page_carry_step(xfer_kind_e kind);
        return (kind == XFER_WORD) ? 2 : 1;
    endfunction

endpackage

// File: rtl/dma_cur_addr.sv
// Module: dma_cur_addr
// Holds the 16-bit current transfer address. A load has priority over a step.
// Flags a rollover step (step at all-ones with no load) for the page logic.
// Assumes: synchronous active-low reset; strobes are single-cycle qualified.
module dma_cur_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic              step,
    output logic [ADDR_W-1:0] cur,
    output logic              rollover
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Rollover: the step that wraps the counter, unless a load overrides it.
    assign rollover = step && !ld && (cur == ALL_ONES);

    // Update the current address: load first, otherwise advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (ld)
            cur <= ld_data;
        else if (step)
            cur <= cur + ONE;
    end

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cur == $past(ld_data));

    // R5
    step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld) |=> cur == $past(cur) + ONE);

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> cur == '0);

endmodule

// File: rtl/dma_page_bank.sv
// Module: dma_page_bank
// Holds the page and upper-page registers and the extended-mode flag.
// An upper-page write arms extended mode. A page write alone disarms it.
// When armed, a rollover advances {upper, page} by 1 (byte) or 2 (word).
// Assumes: page writes have priority over a carry in the same cycle.
module dma_page_bank
    import dma_addr_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int UPAGE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  xfer_kind_e         kind,
    input  logic               page_we,
    input  logic [PAGE_W-1:0]  page_wdata,
    input  logic               upage_we,
    input  logic [UPAGE_W-1:0] upage_wdata,
    input  logic               rollover,
    output logic [PAGE_W-1:0]  page,
    output logic [UPAGE_W-1:0] upage,
    output logic               ext_on
);
    localparam int COMB_W = PAGE_W + UPAGE_W;

    logic [COMB_W-1:0] comb_now;
    logic [COMB_W-1:0] comb_inc;
    logic [COMB_W-1:0] comb_next;
    logic              any_we;
    logic              do_carry;

    assign comb_now = {upage, page};
    assign any_we   = page_we || upage_we;
    assign do_carry = rollover && ext_on && !any_we;

    // Increment amount: the carry enters at bit 0 or bit 1, by channel kind.
    always_comb begin
        comb_inc  = COMB_W'(page_carry_step(kind));
        comb_next = comb_now + comb_inc;
    end

    // Extended-mode flag: an upper-page write wins over a page write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_on <= 1'b0;
        else if (upage_we)
            ext_on <= 1'b1;
        else if (page_we)
            ext_on <= 1'b0;
    end

    // Page register: a write wins, otherwise take the carried value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (page_we)
            page <= page_wdata;
        else if (do_carry)
            page <= comb_next[PAGE_W-1:0];
    end

    // Upper-page register: a write wins, otherwise take the carried value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upage <= '0;
        else if (upage_we)
            upage <= upage_wdata;
        else if (do_carry)
            upage <= comb_next[COMB_W-1:PAGE_W];
    end

    // R6
    wrap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rollover && !ext_on && !any_we) |=> ({upage, page} == $past({upage, page})));

    // R7
    byte_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rollover && ext_on && !any_we && kind == XFER_BYTE)
            |=> ({upage, page} == $past({upage, page}) + COMB_W'(1)));

    // R8
    word_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rollover && ext_on && !any_we && kind == XFER_WORD)
            |=> ({upage, page} == $past({upage, page}) + COMB_W'(2)));

    // R7
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upage_we |=> ext_on);

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_we && !upage_we) |=> !ext_on);

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_we && rollover) |=> page == $past(page_wdata));

endmodule

// File: rtl/dma_addr_map.sv
// Module: dma_addr_map
// Combinational mapping of upper page, page and current address onto the
// physical address. A word channel shifts the address left by one and drops
// page bit 0. Assumes: PHYS_W equals the sum of the three field widths.
module dma_addr_map
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int UPAGE_W = 8
) (
    input  xfer_kind_e                         kind,
    input  logic [UPAGE_W-1:0]                 upage,
    input  logic [PAGE_W-1:0]                  page,
    input  logic [ADDR_W-1:0]                  cur,
    output logic [UPAGE_W+PAGE_W+ADDR_W-1:0]   phys
);
    localparam int PHYS_W = UPAGE_W + PAGE_W + ADDR_W;

    logic [PHYS_W-1:0] byte_form;
    logic [PHYS_W-1:0] word_form;

    // Build both layouts and pick one by channel kind.
    always_comb begin
        byte_form = {upage, page, cur};
        word_form = {upage, page[PAGE_W-1:1], cur, 1'b0};
        phys      = (kind == XFER_WORD) ? word_form : byte_form;
    end

endmodule

// File: rtl/dma_addr_gen.sv
// Module: dma_addr_gen (top)
// Physical address generator for one DMA channel: a current-address counter,
// a page bank with extended-mode carry, and a combinational address mapper.
// Assumes: synchronous active-low reset; all strobes sampled on rising clk.
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int UPAGE_W = 8,
    localparam int PHYS_W = UPAGE_W + PAGE_W + ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_chan,
    input  logic               page_we,
    input  logic [PAGE_W-1:0]  page_wdata,
    input  logic               upage_we,
    input  logic [UPAGE_W-1:0] upage_wdata,
    input  logic               addr_ld,
    input  logic [ADDR_W-1:0]  addr_ld_data,
    input  logic               step,
    output logic [PHYS_W-1:0]  phys_addr
);
    xfer_kind_e         kind;
    logic [ADDR_W-1:0]  cur;
    logic               rollover;
    logic [PAGE_W-1:0]  page;
    logic [UPAGE_W-1:0] upage;
    logic               ext_on;

    assign kind = word_chan ? XFER_WORD : XFER_BYTE;

    dma_cur_addr #(.ADDR_W(ADDR_W)) u_cur (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (addr_ld),
        .ld_data  (addr_ld_data),
        .step     (step),
        .cur      (cur),
        .rollover (rollover)
    );

    dma_page_bank #(.PAGE_W(PAGE_W), .UPAGE_W(UPAGE_W)) u_page (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind        (kind),
        .page_we     (page_we),
        .page_wdata  (page_wdata),
        .upage_we    (upage_we),
        .upage_wdata (upage_wdata),
        .rollover    (rollover),
        .page        (page),
        .upage       (upage),
        .ext_on      (ext_on)
    );

    dma_addr_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .UPAGE_W(UPAGE_W)) u_map (
        .kind  (kind),
        .upage (upage),
        .page  (page),
        .cur   (cur),
        .phys  (phys_addr)
    );

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !addr_ld && !page_we && !upage_we)
            |=> (!$stable(word_chan) || $stable(phys_addr)));

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_chan |-> phys_addr[0] == 1'b0);

endmodule

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_chan = 1'b0;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic        upage_we = 1'b0;
    logic [7:0]  upage_wdata = '0;
    logic        addr_ld = 1'b0;
    logic [15:0] addr_ld_data = '0;
    logic        step = 1'b0;
    logic [31:0] phys_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the architectural state.
    logic [15:0] m_cur = '0;
    logic [7:0]  m_pg  = '0;
    logic [7:0]  m_up  = '0;
    bit          m_ext = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .word_chan(word_chan),
        .page_we(page_we), .page_wdata(page_wdata),
        .upage_we(upage_we), .upage_wdata(upage_wdata),
        .addr_ld(addr_ld), .addr_ld_data(addr_ld_data),
        .step(step), .phys_addr(phys_addr)
    );

    function automatic logic [31:0] expect_addr();
        if (word_chan) return {m_up, m_pg[7:1], m_cur, 1'b0};
        return {m_up, m_pg, m_cur};
    endfunction

    task automatic check(string tag);
        logic [31:0] e;
        e = expect_addr();
        checks++;
        if (phys_addr !== e) begin
            fails++;
            $display("FAIL %s: phys_addr=%08h expected=%08h", tag, phys_addr, e);
        end
    endtask

    // One clock: drive strobes at the falling edge, advance the model, sample after the rise.
    task automatic cyc(bit pw, logic [7:0] pd, bit uw, logic [7:0] ud,
                       bit ld, logic [15:0] ldd, bit st, string tag);
        bit roll;
        @(negedge clk);
        page_we = pw; page_wdata = pd; upage_we = uw; upage_wdata = ud;
        addr_ld = ld; addr_ld_data = ldd; step = st;
        @(posedge clk);
        roll = st && !ld && (m_cur == 16'hFFFF);
        if (ld) m_cur = ldd; else if (st) m_cur = m_cur + 16'd1;
        if (!pw && !uw && roll && m_ext)
            {m_up, m_pg} = {m_up, m_pg} + (word_chan ? 16'd2 : 16'd1);
        if (pw) m_pg = pd;
        if (uw) m_up = ud;
        if (uw) m_ext = 1'b1; else if (pw) m_ext = 1'b0;
        #1;
        page_we = 0; upage_we = 0; addr_ld = 0; step = 0;
        check(tag);
    endtask

    task automatic set_kind(bit w);
        @(negedge clk);
        word_chan = w;
        #1;
        check(w ? "R3" : "R2");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1");

        // R2 / R3 mapping sweep with and without an upper-page value.
        for (int w = 0; w < 2; w++) begin
            set_kind(w[0]);
            for (int p = 0; p < 256; p += 17) begin
                cyc(1, p[7:0], 0, 8'h00, 1, 16'(p * 257 + 3), 0, w ? "R3" : "R2");
                cyc(0, 8'h00, 1, 8'(p ^ 8'hA5), 0, 16'h0, 0, w ? "R3" : "R2");
                cyc(1, 8'(p | 1), 0, 8'h00, 0, 16'h0, 0, "R3");
            end
        end

        // R5 / R6 / R7 / R8: steps across 0xFFFF with every channel/mode combination.
        for (int w = 0; w < 2; w++) begin
            set_kind(w[0]);
            for (int e = 0; e < 2; e++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [7:0] pg;
                    pg = (p == 3) ? 8'hFF : ((p == 2) ? 8'hFE : 8'(p * 37 + 1));
                    cyc(1, pg, 0, 8'h00, 1, 16'hFFFD, 0, "R4");
                    if (e) cyc(0, 8'h00, 1, 8'h7E, 0, 16'h0, 0, "R7");
                    for (int s = 0; s < 4; s++)
                        cyc(0, 8'h00, 0, 8'h00, 0, 16'h0, 1,
                            e ? (w ? "R8" : "R7") : (s == 2 ? "R6" : "R5"));
                end
            end
        end

        // R9: page write alone disarms; both writes together arm.
        set_kind(1'b0);
        cyc(0, 8'h00, 1, 8'h11, 1, 16'hFFFF, 0, "R7");
        cyc(1, 8'h22, 0, 8'h00, 0, 16'h0, 0, "R9");
        cyc(0, 8'h00, 0, 8'h00, 0, 16'h0, 1, "R9");
        cyc(1, 8'h33, 1, 8'h44, 1, 16'hFFFF, 0, "R9");
        cyc(0, 8'h00, 0, 8'h00, 0, 16'h0, 1, "R9");

        // R11: a page write during a rollover step drops the carry.
        cyc(0, 8'h00, 1, 8'h50, 1, 16'hFFFF, 0, "R11");
        cyc(0, 8'h00, 1, 8'h60, 0, 16'h0, 1, "R11");
        cyc(0, 8'h00, 0, 8'h00, 1, 16'hFFFF, 0, "R11");
        cyc(1, 8'h70, 0, 8'h00, 0, 16'h0, 1, "R11");

        // R4: load and step together, load wins (also at 0xFFFF with extended mode).
        cyc(0, 8'h00, 1, 8'h01, 1, 16'hFFFF, 0, "R4");
        cyc(0, 8'h00, 0, 8'h00, 1, 16'h1234, 1, "R4");
        cyc(0, 8'h00, 0, 8'h00, 1, 16'hFFFF, 0, "R4");
        cyc(0, 8'h00, 0, 8'h00, 1, 16'h0042, 1, "R4");

        // R10: idle cycles hold the output.
        for (int i = 0; i < 5; i++)
            cyc(0, 8'h00, 0, 8'h00, 0, 16'h0, 0, "R10");
        set_kind(1'b1);
        for (int i = 0; i < 3; i++)
            cyc(0, 8'h00, 0, 8'h00, 0, 16'h0, 0, "R10");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule